// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

A 32-bit processor that completes one instruction on every rising clock edge. It runs a nine-instruction subset: five register-to-register operations (add, subtract, bitwise AND, bitwise OR, signed set-less-than), an add-immediate, a word load, a word store and a branch-if-equal. The program counter fetches from a word-addressed instruction memory. A 32-entry register file, an ALU and a word-addressed data memory form the datapath. A controller made of a main decoder and an ALU-operation decoder drives the datapath through a control bundle. The ALU's zero flag comes back to the controller as its only status signal, and the controller uses it to decide whether a branch is taken.

A loading port writes instruction words into the instruction memory while the core is held in reset. A debug port reads any one register combinationally, so a bench can inspect results without disturbing execution.

Top module: `sc_core`

## Requirements
- R1: R-type words (opcode 000000) with funct 100000 write rs+rt into rd, and with funct 100010 write rs-rt into rd. Both results wrap modulo 2^32. Fields are rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0].
- R2: Register 0 always reads as zero, and a write aimed at register 0 has no effect.
- R3: R-type funct 100100 writes the bitwise AND of rs and rt into rd, and funct 100101 writes their bitwise OR.
- R4: R-type funct 101010 writes 1 into rd when rs is less than rt as signed two's-complement numbers, and writes 0 otherwise. This holds when rs-rt overflows.
- R5: Opcode 100011 (load) loads rt from data word ((rs + sext(imm[15:0])) >> 2) mod DMEM_WORDS. Opcode 101011 (store) writes rt to that word on the clock edge. Only the store writes data memory.
- R6: Opcode 001000 (add immediate) writes rs + sext(imm[15:0]) into rt.
- R7: Each cycle the core executes the instruction at word (PC >> 2) mod IMEM_WORDS, and the PC then advances by 4.
- R8: Opcode 000100 (branch) compares rs with rt. When they are equal, the next PC is PC+4+(sext(imm)<<2). Otherwise the next PC is PC+4.
- R9: While rst is high, the PC is set to 0 at each edge and no register or data-memory write takes place. Register and memory contents survive reset. The first edge after reset executes word 0.
- R10: An unrecognised opcode, or an R-type word with an unrecognised funct, writes neither a register nor data memory.
- R11: When load_we is high, load_data is written on the rising edge into instruction word load_addr.
- R12: dbg_data shows the register selected by dbg_sel combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Instruction-memory write strobe |
| load_addr | input | $clog2(IMEM_WORDS) | Instruction word index to write |
| load_data | input | 32 | Instruction word to write |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The hardest cases to reach from the ports are operand values near the signed limits. The set-less-than overflow correction and the wrap of add and subtract only show up there. The only way to load a constant is a 16-bit immediate, so the bench builds each 32-bit operand inside the program. It adds a high half to register 0, doubles the register sixteen times and adds a sign-corrected low half. It then sweeps every pair of six boundary values through all five register operations. A backward branch loop and address wrap-around in data memory are covered by dedicated programs.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    mem_we;
    logic    mem_to_reg;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  // signed less-than from the difference sign, corrected by overflow
  function automatic logic signed_lt(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic [XLEN-1:0] d;
    logic ovf;
    d   = a - b;
    ovf = (a[XLEN-1] ^ b[XLEN-1]) & (a[XLEN-1] ^ d[XLEN-1]);
    return d[XLEN-1] ^ ovf;
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, signed_lt(a, b)};
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc_plus4,
                                                  input logic [15:0] off);
    return pc_plus4 + (sext16(off) << 2);
  endfunction
endpackage

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    y    = alu_eval(op, a, b);
    zero = (y == '0);
  end
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [XLEN-1:0]   wd,
  input  logic [REG_AW-1:0] ra1,
  input  logic [REG_AW-1:0] ra2,
  input  logic [REG_AW-1:0] ra3,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2,
  output logic [XLEN-1:0]   rd3
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/sc_decoder.sv
`timescale 1ns/1ps
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       zero,
  output ctrl_t      ctrl,
  output logic       pc_take,
  output logic       illegal
);
  always_comb begin
    ctrl    = '0;
    illegal = 1'b0;
    case (opcode)
      OP_RTYPE: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst_rd = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: begin
            ctrl.reg_we = 1'b0;
            illegal     = 1'b1;
          end
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_LW: begin
        ctrl.reg_we     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: illegal = 1'b1;
    endcase
    pc_take = ctrl.is_branch & zero;
  end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 128,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic [IAW-1:0]    load_addr,
  input  logic [XLEN-1:0]   load_data,
  input  logic [REG_AW-1:0] dbg_sel,
  output logic [XLEN-1:0]   dbg_data
);
  logic [XLEN-1:0] pc_q, pc_plus4, br_target, instr;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // fetch
  assign instr    = imem[pc_q[IAW+1:2]];
  assign pc_plus4 = pc_q + 32'd4;

  always_ff @(posedge clk) begin
    if (load_we) imem[load_addr] <= load_data;
  end

  // field split
  logic [5:0]        opcode, funct;
  logic [REG_AW-1:0] rs_addr, rt_addr, rd_addr, dst_addr;
  logic [15:0]       imm;
  assign opcode  = instr[31:26];
  assign rs_addr = instr[25:21];
  assign rt_addr = instr[20:16];
  assign rd_addr = instr[15:11];
  assign imm     = instr[15:0];
  assign funct   = instr[5:0];

  // controller: control bundle out, zero flag in
  ctrl_t ctrl;
  logic  pc_take, illegal, alu_zero;
  sc_decoder u_dec (
    .opcode (opcode),
    .funct  (funct),
    .zero   (alu_zero),
    .ctrl   (ctrl),
    .pc_take(pc_take),
    .illegal(illegal)
  );

  // datapath
  logic            rf_we, dm_we;
  logic [XLEN-1:0] rs_data, rt_data, wb_data, alu_b, alu_y, dm_rdata;
  logic [DAW-1:0]  dm_addr;

  assign rf_we    = ctrl.reg_we & ~rst;
  assign dm_we    = ctrl.mem_we & ~rst;
  assign dst_addr = ctrl.dst_rd ? rd_addr : rt_addr;

  sc_regfile u_rf (
    .clk(clk),
    .we (rf_we),
    .wa (dst_addr),
    .wd (wb_data),
    .ra1(rs_addr),
    .ra2(rt_addr),
    .ra3(dbg_sel),
    .rd1(rs_data),
    .rd2(rt_data),
    .rd3(dbg_data)
  );

  assign alu_b = ctrl.use_imm ? sext16(imm) : rt_data;

  sc_alu u_alu (
    .op  (ctrl.alu_op),
    .a   (rs_data),
    .b   (alu_b),
    .y   (alu_y),
    .zero(alu_zero)
  );

  assign dm_addr  = alu_y[DAW+1:2];
  assign dm_rdata = dmem[dm_addr];
  assign wb_data  = ctrl.mem_to_reg ? dm_rdata : alu_y;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[dm_addr] <= rt_data;
  end

  assign br_target = branch_dest(pc_plus4, imm);

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (pc_take) pc_q <= br_target;
    else              pc_q <= pc_plus4;
  end

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc_q[1:0], pc_q[XLEN-1:IAW+2],
                         alu_y[1:0], alu_y[XLEN-1:DAW+2]};
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] br_target,
  input logic        pc_take,
  input logic        illegal,
  input logic        rf_we,
  input logic        dm_we,
  input logic [5:0]  opcode,
  input logic [4:0]  rs_addr,
  input logic [31:0] rs_data
);
  // R9
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == 32'd0);

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_take |=> pc == $past(pc) + 32'd4);

  // R8
  branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
    pc_take |=> pc == $past(br_target));

  // R8
  branch_only_chk: assert property (@(posedge clk) disable iff (rst)
    pc_take |-> opcode == 6'b000100);

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we && !dm_we));

  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> opcode == 6'b101011);

  // R2
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    rs_addr == 5'd0 |-> rs_data == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .br_target(br_target),
  .pc_take  (pc_take),
  .illegal  (illegal),
  .rf_we    (rf_we),
  .dm_we    (dm_we),
  .opcode   (opcode),
  .rs_addr  (rs_addr),
  .rs_data  (rs_data)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam int IW = 128;

  logic        clk = 1'b0;
  logic        rst;
  logic        load_we;
  logic [6:0]  load_addr;
  logic [31:0] load_data;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] prog [IW];
  int plen;

  always #5 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction

  task automatic put(logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    plen = 0;
  endtask

  // build a 32-bit constant with add-immediate and doubling
  task automatic set_const(int r, logic [31:0] v);
    logic [31:0] lo_s, hi_part;
    lo_s    = {{16{v[15]}}, v[15:0]};
    hi_part = v - lo_s;
    put(enc_i(6'b001000, 0, r, hi_part[31:16]));
    for (int k = 0; k < 16; k++) put(enc_r(r, r, r, 6'b100000));
    put(enc_i(6'b001000, r, r, v[15:0]));
  endtask

  task automatic load_prog();
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      load_we   = 1'b1;
      load_addr = 7'(i);
      load_data = prog[i];
    end
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic run(int n);
    @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b1;
  endtask

  task automatic chk(string req, int r, logic [31:0] exp);
    dbg_sel = 5'(r);
    #1;
    checks++;
    if (dbg_data !== exp) begin
      fails++;
      $display("FAIL %s reg%0d actual=%h expected=%h", req, r, dbg_data, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [31:0] vals [6];

  initial begin
    rst = 1'b1; load_we = 1'b0; load_addr = '0; load_data = '0; dbg_sel = '0;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0005; vals[2] = 32'hFFFF_FFFD;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
    repeat (2) @(negedge clk);

    // R9 / R11: first edge after reset runs word 0 only
    clear_prog();
    put(enc_i(6'b001000, 0, 25, 16'd1));
    put(enc_i(6'b001000, 0, 25, 16'd2));
    load_prog();
    run(1);
    chk("R9", 25, 32'd1);
    run(2);
    chk("R11", 25, 32'd2);

    // operand sweep: R1 R3 R4
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] a, b;
        a = vals[i];
        b = vals[j];
        clear_prog();
        set_const(1, a);
        set_const(2, b);
        put(enc_r(1, 2, 3, 6'b100000));
        put(enc_r(1, 2, 4, 6'b100010));
        put(enc_r(1, 2, 5, 6'b100100));
        put(enc_r(1, 2, 6, 6'b100101));
        put(enc_r(1, 2, 7, 6'b101010));
        put(enc_r(2, 1, 8, 6'b101010));
        load_prog();
        run(plen);
        chk("R12", 1, a);
        chk("R1", 3, a + b);
        chk("R1", 4, a - b);
        chk("R3", 5, a & b);
        chk("R3", 6, a | b);
        chk("R4", 7, {31'd0, $signed(a) < $signed(b)});
        chk("R4", 8, {31'd0, $signed(b) < $signed(a)});
      end
    end

    // memory, immediate, register 0 and unrecognised words
    clear_prog();
    put(enc_i(6'b001000, 0, 1, 16'd100));
    put(enc_i(6'b001000, 0, 2, 16'h1234));
    put(enc_i(6'b001000, 0, 3, 16'hFFB3));
    put(enc_i(6'b101011, 1, 2, 16'd8));        // word 27
    put(enc_i(6'b101011, 1, 3, 16'hFFFC));     // word 24
    put(enc_i(6'b100011, 1, 4, 16'd8));
    put(enc_i(6'b100011, 1, 5, 16'hFFFC));
    put(enc_i(6'b100011, 1, 7, 16'd264));      // word 91 mod 64 = 27
    put(enc_i(6'b101000, 1, 3, 16'd8));        // unrecognised store-like word
    put(enc_i(6'b100011, 1, 8, 16'd8));
    put(enc_i(6'b001000, 0, 9, 16'd11));
    put(enc_i(6'b000010, 0, 9, 16'd5));        // unrecognised opcode, rt=9
    put(enc_i(6'b001000, 0, 10, 16'd12));
    put(enc_r(1, 1, 10, 6'b100001));           // unrecognised funct, rd=10
    put(enc_i(6'b001000, 0, 12, 16'hFFFB));
    put(enc_i(6'b001000, 12, 13, 16'h7FFF));
    put(enc_i(6'b001000, 0, 0, 16'd7));
    put(enc_r(0, 0, 11, 6'b100000));
    load_prog();
    run(plen);
    chk("R5", 4, 32'h0000_1234);
    chk("R5", 5, 32'hFFFF_FFB3);
    chk("R5", 7, 32'h0000_1234);
    chk("R10", 8, 32'h0000_1234);
    chk("R10", 9, 32'd11);
    chk("R10", 10, 32'd12);
    chk("R6", 12, 32'hFFFF_FFFB);
    chk("R6", 13, 32'h0000_7FFA);
    chk("R2", 0, 32'd0);
    chk("R2", 11, 32'd0);

    // branches: forward taken, not taken, backward loop
    clear_prog();
    put(enc_i(6'b001000, 0, 14, 16'd77));
    put(enc_i(6'b001000, 0, 1, 16'd3));
    put(enc_i(6'b001000, 0, 2, 16'd3));
    put(enc_i(6'b001000, 0, 3, 16'd4));
    put(enc_i(6'b000100, 1, 2, 16'd2));        // word 4 -> word 7
    put(enc_i(6'b001000, 0, 14, 16'd1));
    put(enc_i(6'b001000, 0, 14, 16'd2));
    put(enc_i(6'b001000, 0, 16, 16'd9));
    put(enc_i(6'b000100, 1, 3, 16'd5));        // not taken
    put(enc_i(6'b001000, 0, 17, 16'd21));
    put(enc_i(6'b001000, 0, 20, 16'd0));
    put(enc_i(6'b001000, 0, 21, 16'd4));
    put(enc_i(6'b001000, 20, 20, 16'd1));      // word 12 loop head
    put(enc_i(6'b000100, 20, 21, 16'd1));      // exit -> word 15
    put(enc_i(6'b000100, 0, 0, 16'hFFFD));     // back to word 12
    put(enc_i(6'b001000, 0, 22, 16'd55));
    load_prog();
    run(40);
    chk("R8", 14, 32'd77);
    chk("R8", 16, 32'd9);
    chk("R8", 17, 32'd21);
    chk("R8", 20, 32'd4);
    chk("R7", 22, 32'd55);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule